// File: doc/BRIEF.md
# Multiplexed Scan Chain Test Sequencer

This block holds a parameterised chain of multiplexed scan cells together with the controller that runs a complete scan test session on it. A single `start` strobe begins the session. The controller first proves that the chain shifts correctly. The tester feeds a known alternating bit stream into the serial input, and the block compares what comes out of the far end. After that the controller runs the pattern loop. It loads a pattern by shifting, gives one functional capture clock, and then unloads that response while the next pattern is shifted in.

The tester supplies the serial stimulus and flags the last pattern. It also drives the functional response into the parallel data input during each capture cycle. The block exposes the cell contents on its parallel output, so the logic under test sees the loaded pattern. It raises a chain-fault flag when the integrity comparison fails, and it pulses `done` once the final response has been unloaded. Pattern storage and response comparison stay with the tester.

Top module: `scan_seq_top`

## Requirements
- R1: A synchronous active-high `rst` returns the block to idle from any state. From the cycle after the reset edge, `scan_en`, `done` and `chain_fault` are 0 and every cell, and therefore `func_q`, is 0.
- R2: While `scan_en` is 0 (idle, capture, final cycle), every cell loads its own bit of `func_d` at each clock, so `func_q` equals the `func_d` of the previous cycle.
- R3: While `scan_en` is 1, cell 0 takes `scan_in`, cell k takes cell k-1, and `scan_out` shows cell CHAIN_LEN-1. After CHAIN_LEN shifts, a pattern sent highest bit first ends with bit k in cell k.
- R4: A `start` seen in idle puts the block into the chain test from the next cycle. The chain test keeps `scan_en` at 1 for exactly CHAIN_LEN+1 cycles.
- R5: During the chain test, cycle c (counted from 0) expects `scan_in` = 1 for even c and 0 for odd c. In the last chain-test cycle and in each of the first load's CHAIN_LEN cycles, `scan_out` must equal the bit injected CHAIN_LEN cycles earlier. A mismatch sets `chain_fault` from the next cycle on. The flag holds until the next accepted `start` or a reset.
- R6: After the chain test, each pattern load lasts exactly CHAIN_LEN cycles with `scan_en` at 1. It is followed by a single capture cycle with `scan_en` at 0. During that cycle `func_q` shows the loaded pattern, and `func_d` is stored at its end.
- R7: In load cycle j of every load except the first, `scan_out` shows bit CHAIN_LEN-1-j of the previously captured response.
- R8: `last_pat` is sampled in the capture cycle. When it is 0, the next load starts in the following cycle. When it is 1, a final unload of CHAIN_LEN cycles with `scan_en` at 1 follows, presenting the response as in R7.
- R9: For P patterns, the load/capture/unload phase lasts P*(CHAIN_LEN+1)+CHAIN_LEN cycles. `done` is 1 for exactly the single cycle right after it, and the block is then idle with `scan_en` at 0.
- R10: `start` has no effect while a session is running; the timing of R6 to R9 is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a session (accepted in idle only) |
| last_pat | input | 1 | Pattern just captured is the last one; sampled in the capture cycle |
| scan_in | input | 1 | Serial stimulus into cell 0 |
| func_d | input | CHAIN_LEN | Functional response captured when scan_en is 0 |
| func_q | output | CHAIN_LEN | Cell contents driven toward the logic under test |
| scan_out | output | 1 | Serial output of the last cell |
| scan_en | output | 1 | 1 while shifting, 0 in functional/capture cycles |
| done | output | 1 | One-cycle pulse after the final unload |
| chain_fault | output | 1 | Sticky chain-integrity failure flag |

## Verification
The unload of one response and the load of the next pattern share every shift cycle. The bench runs sessions of several random patterns with random responses back to back. In each load cycle it compares `scan_out` against the earlier response, while the bits it pushes in must later appear on `func_q` at capture. The tail of the chain test also shares cycles with the first load. A session that flips one injected bit has to raise `chain_fault`, and the next session must clear it.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CHECK,
      ST_LOAD,
      ST_CAPT,
      ST_UNLOAD,
      ST_FIN
   } seq_state_t;

endpackage

// File: rtl/scan_cell_chain.sv
module scan_cell_chain #(
   parameter int CHAIN_LEN = 8
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 shift_en,
   input  logic                 ser_in,
   input  logic [CHAIN_LEN-1:0] par_in,
   output logic [CHAIN_LEN-1:0] cells,
   output logic                 ser_out
);

   for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_cell
      logic q;
      logic shift_src;
      if (i == 0) begin : g_head
         assign shift_src = ser_in;
      end else begin : g_body
         assign shift_src = g_cell[i-1].q;
      end
      always_ff @(posedge clk) begin
         if (rst)           q <= 1'b0;
         else if (shift_en) q <= shift_src;
         else               q <= par_in[i];
      end
      assign cells[i] = q;
   end

   assign ser_out = cells[CHAIN_LEN-1];

endmodule

// File: rtl/scan_integrity_chk.sv
module scan_integrity_chk (
   input  logic clk,
   input  logic rst,
   input  logic launch,
   input  logic cmp_en,
   input  logic ser_out,
   output logic fault
);

   logic exp_bit;

   always_ff @(posedge clk) begin
      if (rst)         exp_bit <= 1'b0;
      else if (launch) exp_bit <= 1'b1;
      else if (cmp_en) exp_bit <= ~exp_bit;
   end

   always_ff @(posedge clk) begin
      if (rst)                              fault <= 1'b0;
      else if (launch)                      fault <= 1'b0;
      else if (cmp_en && ser_out != exp_bit) fault <= 1'b1;
   end

   // R5: a raised flag survives until a new session or reset
   assert_fault_sticky_R5: assert property (@(posedge clk) disable iff (rst)
      (fault && !launch) |=> fault);
   assert_fault_clear_R5: assert property (@(posedge clk) disable iff (rst)
      launch |=> !fault);

endmodule

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
   import scan_seq_pkg::*;
#(
   parameter int CHAIN_LEN = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   input  logic last_pat,
   output logic scan_en,
   output logic done,
   output logic launch,
   output logic cmp_en
);

   localparam int CNT_W = $clog2(CHAIN_LEN + 1);
   localparam logic [CNT_W-1:0] CHK_LAST   = CNT_W'(CHAIN_LEN);
   localparam logic [CNT_W-1:0] SHIFT_LAST = CNT_W'(CHAIN_LEN - 1);

   seq_state_t       state, state_nx;
   logic [CNT_W-1:0] cnt, cnt_nx;
   logic             first_ld, first_ld_nx;

   always_comb begin
      state_nx    = state;
      cnt_nx      = cnt;
      first_ld_nx = first_ld;
      unique case (state)
         ST_IDLE: begin
            if (start) begin
               state_nx = ST_CHECK;
               cnt_nx   = '0;
            end
         end
         ST_CHECK: begin
            if (cnt == CHK_LAST) begin
               state_nx    = ST_LOAD;
               cnt_nx      = '0;
               first_ld_nx = 1'b1;
            end else begin
               cnt_nx = cnt + 1'b1;
            end
         end
         ST_LOAD: begin
            if (cnt == SHIFT_LAST) begin
               state_nx    = ST_CAPT;
               cnt_nx      = '0;
               first_ld_nx = 1'b0;
            end else begin
               cnt_nx = cnt + 1'b1;
            end
         end
         ST_CAPT: begin
            state_nx = last_pat ? ST_UNLOAD : ST_LOAD;
            cnt_nx   = '0;
         end
         ST_UNLOAD: begin
            if (cnt == SHIFT_LAST) begin
               state_nx = ST_FIN;
               cnt_nx   = '0;
            end else begin
               cnt_nx = cnt + 1'b1;
            end
         end
         ST_FIN: state_nx = ST_IDLE;
         default: begin
            state_nx = ST_IDLE;
            cnt_nx   = '0;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         first_ld <= 1'b0;
      end else begin
         state    <= state_nx;
         cnt      <= cnt_nx;
         first_ld <= first_ld_nx;
      end
   end

   assign scan_en = (state == ST_CHECK) || (state == ST_LOAD) || (state == ST_UNLOAD);
   assign done    = (state == ST_FIN);
   assign launch  = (state == ST_IDLE) && start;
   assign cmp_en  = ((state == ST_CHECK) && (cnt == CHK_LAST)) ||
                    ((state == ST_LOAD) && first_ld);

   // R4: counter stays inside the longest phase
   assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
      cnt <= CHK_LAST);
   // R4: an accepted start begins shifting at once
   assert_start_shift_R4: assert property (@(posedge clk) disable iff (rst)
      (state == ST_IDLE && start) |=> scan_en);
   // R6: capture never lasts two cycles
   assert_capt_once_R6: assert property (@(posedge clk) disable iff (rst)
      (state == ST_CAPT) |=> (state != ST_CAPT));
   // R9: done is a single-cycle pulse following the unload
   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
   assert_done_after_unload_R9: assert property (@(posedge clk) disable iff (rst)
      (state == ST_UNLOAD && cnt == SHIFT_LAST) |=> done);

endmodule

// File: rtl/scan_seq_top.sv
module scan_seq_top #(
   parameter int CHAIN_LEN = 8
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 start,
   input  logic                 last_pat,
   input  logic                 scan_in,
   input  logic [CHAIN_LEN-1:0] func_d,
   output logic [CHAIN_LEN-1:0] func_q,
   output logic                 scan_out,
   output logic                 scan_en,
   output logic                 done,
   output logic                 chain_fault
);

   if (CHAIN_LEN < 2) begin : g_len_check
      $error("scan_seq_top: CHAIN_LEN must be at least 2");
   end

   logic launch;
   logic cmp_en;

   scan_seq_ctrl #(.CHAIN_LEN(CHAIN_LEN)) u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .start    (start),
      .last_pat (last_pat),
      .scan_en  (scan_en),
      .done     (done),
      .launch   (launch),
      .cmp_en   (cmp_en)
   );

   scan_cell_chain #(.CHAIN_LEN(CHAIN_LEN)) u_chain (
      .clk      (clk),
      .rst      (rst),
      .shift_en (scan_en),
      .ser_in   (scan_in),
      .par_in   (func_d),
      .cells    (func_q),
      .ser_out  (scan_out)
   );

   scan_integrity_chk u_integ (
      .clk     (clk),
      .rst     (rst),
      .launch  (launch),
      .cmp_en  (cmp_en),
      .ser_out (scan_out),
      .fault   (chain_fault)
   );

endmodule

// File: tb/scan_seq_top_bench.sv
module scan_seq_top_bench;

   localparam int M = 8;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         start = 1'b0;
   logic         last_pat = 1'b0;
   logic         scan_in = 1'b0;
   logic [M-1:0] func_d = '0;
   logic [M-1:0] func_q;
   logic         scan_out;
   logic         scan_en;
   logic         done;
   logic         chain_fault;

   int n_chk  = 0;
   int n_fail = 0;
   bit ended  = 1'b0;

   always #4 clk = ~clk;

   scan_seq_top #(.CHAIN_LEN(M)) u_scan_seq_top (
      .clk(clk), .rst(rst), .start(start), .last_pat(last_pat),
      .scan_in(scan_in), .func_d(func_d), .func_q(func_q),
      .scan_out(scan_out), .scan_en(scan_en), .done(done),
      .chain_fault(chain_fault)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic inj_bit(input int c);
      return (c % 2 == 0) ? 1'b1 : 1'b0;
   endfunction

   function automatic logic [M-1:0] resp_of(input logic [M-1:0] p, input int salt);
      return p ^ {p[0], p[M-1:1]} ^ M'(salt);
   endfunction

   task automatic session(input int npat, input int flip_at, input bit poke);
      logic [M-1:0] pats [4];
      logic [M-1:0] resps [4];
      logic         sent [M+1];
      for (int p = 0; p < npat; p++) begin
         pats[p]  = M'($urandom);
         resps[p] = resp_of(pats[p], p * 37 + 5);
      end
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int c = 0; c <= M; c++) begin
         check(scan_en == 1'b1, "R4 chain test scan_en", 32'(scan_en), 32'd1);
         if (c == 1)
            check(chain_fault == 1'b0, "R5 fault cleared by start", 32'(chain_fault), 32'd0);
         sent[c] = inj_bit(c) ^ (c == flip_at);
         if (c == M)
            check(scan_out == sent[0], "R5 first injected bit out", 32'(scan_out), 32'(sent[0]));
         scan_in = sent[c];
         func_d  = M'($urandom);
         @(negedge clk);
      end
      for (int p = 0; p < npat; p++) begin
         for (int j = 0; j < M; j++) begin
            check(scan_en == 1'b1, "R6 load scan_en", 32'(scan_en), 32'd1);
            if (p == 0)
               check(scan_out == sent[j+1], "R3 integrity tail on scan_out",
                     32'(scan_out), 32'(sent[j+1]));
            else
               check(scan_out == resps[p-1][M-1-j], "R7 response unload during load",
                     32'(scan_out), 32'(resps[p-1][M-1-j]));
            start   = poke && (p == 0) && (j == 2);   // R10 stray start
            scan_in = pats[p][M-1-j];
            func_d  = M'($urandom);
            @(negedge clk);
         end
         start = 1'b0;
         check(scan_en == 1'b0, "R6 capture scan_en", 32'(scan_en), 32'd0);
         check(func_q == pats[p], "R3 R6 loaded pattern on func_q", 32'(func_q), 32'(pats[p]));
         func_d   = resps[p];
         last_pat = (p == npat - 1);
         @(negedge clk);
         last_pat = 1'b0;
      end
      for (int j = 0; j < M; j++) begin
         check(scan_en == 1'b1, "R8 final unload scan_en", 32'(scan_en), 32'd1);
         check(scan_out == resps[npat-1][M-1-j], "R8 final unload data",
               32'(scan_out), 32'(resps[npat-1][M-1-j]));
         scan_in = 1'($urandom);
         @(negedge clk);
      end
      check(done == 1'b1, "R9 done after final unload", 32'(done), 32'd1);
      check(chain_fault == (flip_at >= 0), "R5 chain_fault result",
            32'(chain_fault), 32'(flip_at >= 0));
      @(negedge clk);
      check(done == 1'b0, "R9 done single cycle", 32'(done), 32'd0);
      check(scan_en == 1'b0, "R9 idle after done", 32'(scan_en), 32'd0);
   endtask

   initial begin
      logic [M-1:0] v;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst = 1'b0;
      check(scan_en == 1'b0 && done == 1'b0, "R1 reset outputs",
            32'({scan_en, done}), 32'd0);
      check(func_q == '0 && chain_fault == 1'b0, "R1 reset cells",
            32'({chain_fault, func_q}), 32'd0);
      v = M'($urandom);
      func_d = v;
      @(negedge clk);
      check(func_q == v, "R2 idle functional load", 32'(func_q), 32'(v));
      session(1, -1, 1'b0);
      session(3, -1, 1'b1);
      session(1, 3, 1'b0);
      session(4, -1, 1'b0);
      session(2, 0, 1'b0);
      // R1 reset in the middle of a session
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check(scan_en == 1'b0 && done == 1'b0 && chain_fault == 1'b0,
            "R1 mid-run reset outputs", 32'({scan_en, done, chain_fault}), 32'd0);
      check(func_q == '0, "R1 mid-run reset cells", 32'(func_q), 32'd0);
      rst = 1'b0;
      @(negedge clk);
      if (!ended) begin
         ended = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      #(8 * 20000);
      if (!ended) begin
         ended = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule